// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block takes command frames for a multi-channel DAC from a three-wire serial link and turns them into parallel words. The three wires are an active-low frame select, a serial clock and a data line. While select is low, each falling edge of the serial clock shifts one data bit into a frame register, most significant bit first. When the last bit of a frame arrives, the frame is split into a command, a channel address and a data value. The block then emits a one-cycle strobe in the system clock domain, together with the registered fields.

All three serial pins are brought into the system clock through flip-flop synchronisers, and the edges are found there. For this reason the system clock must run at least four times faster than the serial clock. If select rises before the frame is complete, the frame is thrown away. Nothing reaches the outputs in that case, and the next frame starts from an empty register.

The data field has two layouts, chosen by the address. Four of the channels carry 16 bits of data. The other four carry 12 bits, which are placed in the low bits of the 16-bit output. Addresses above the channel range address all channels at once and use the 16-bit layout.

The output is a plain strobe with no back-pressure. The sender on the serial link cannot be stalled, so the consumer must take the fields in the cycle where `upd_valid` is high. The fields stay stable until the next complete frame.

Top module: `dac_cmd_rx`

## Requirements
- R1: After reset, `upd_valid` is low and `upd_cmd`, `upd_addr` and `upd_data` are all zero.
- R2: Each complete frame of 32 bits produces exactly one `upd_valid` pulse, one system clock wide. The bits of the frame are taken MSB first, so the first bit shifted in becomes bit 31.
- R3: `upd_cmd` equals frame bits 27..24 and `upd_addr` equals frame bits 23..20. Frame bits 31..28 have no effect on any output.
- R4: For addresses 0, 1, 6 and 7, `upd_data` equals frame bits 19..4. Frame bits 3..0 have no effect.
- R5: For addresses 2, 3, 4 and 5, `upd_data` equals frame bits 19..8 in its bits 11..0, and its bits 15..12 are zero. Frame bits 7..0 have no effect.
- R6: For addresses 8 to 15 (all channels), `upd_data` uses the 16-bit layout of R4.
- R7: If select rises after fewer than 32 falling edges, no strobe is produced. All output fields keep their previous values.
- R8: Falling edges after the 32nd edge and before select rises are ignored. Such a frame gives one strobe, with the fields taken from its first 32 bits.
- R9: Every frame starts with an empty shift register and a bit count of zero, so a frame sent right after an aborted frame is decoded correctly.
- R10: The strobe follows the 32nd falling edge within a few system clock cycles and does not wait for select to rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Frame select, active low, asynchronous to clk |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat | input | 1 | Serial data, MSB first |
| upd_valid | output | 1 | One-cycle strobe for a complete frame |
| upd_cmd | output | 4 | Command field of the last complete frame |
| upd_addr | output | 4 | Channel address of the last complete frame |
| upd_data | output | 16 | Data of the last complete frame, zero-extended for 12-bit channels |

## Verification
The bench uses the default parameters: a 32-bit frame, two synchroniser stages, and 16-bit and 12-bit data layouts. With these values the bit positions stated in the requirements apply exactly. The serial clock runs at one eighth of the system clock, well above the minimum ratio of four. Each serial edge therefore spans several synchronised samples, and the bench can place aborts at the first, middle and last bit of a frame. It also sends over-length frames and reaches both narrow-address boundaries (2 and 5) as well as the edges of the broadcast range (8 and 15).

// File: rtl/dac_rx_pkg.sv
`timescale 1ns/1ps
package dac_rx_pkg;

  // How the data field of a frame is laid out for a given address.
  typedef enum logic [1:0] {
    GRP_WIDE   = 2'd0,
    GRP_NARROW = 2'd1,
    GRP_ALL    = 2'd2
  } chan_grp_e;

  // Range of addresses that use the 12-bit data layout.
  localparam int NARROW_ADDR_LO = 2;
  localparam int NARROW_ADDR_HI = 5;
  // Addresses at or above this value go to all channels.
  localparam int BCAST_ADDR_LO  = 8;

endpackage

// File: rtl/dac_rx_sync.sv
`timescale 1ns/1ps
module dac_rx_sync #(
  parameter int         WIDTH     = 3,
  parameter int         STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RESET_VAL;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RESET_VAL;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dac_rx_shifter.sv
`timescale 1ns/1ps
module dac_rx_shifter #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  sel_s,
  input  logic                  din_s,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  frame_done
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_q, sel_q;
  logic                  sclk_fall, sel_fall;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic                  full;
  logic                  done;

  assign sclk_fall = sclk_q & ~sclk_s;
  assign sel_fall  = sel_q & ~sel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sel_q  <= 1'b1;
      cnt    <= '0;
      shreg  <= '0;
      full   <= 1'b0;
      done   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sel_q  <= sel_s;
      done   <= 1'b0;
      if (sel_s || sel_fall) begin
        // Select high (abort or idle), or a new frame starting: clear everything.
        cnt   <= '0;
        shreg <= '0;
        full  <= 1'b0;
      end else if (sclk_fall && !full) begin
        shreg <= {shreg[FRAME_BITS-2:0], din_s};
        cnt   <= cnt + 1'b1;
        if (cnt == LAST_IDX) begin
          full <= 1'b1;
          done <= 1'b1;
        end
      end
    end
  end

  assign frame_word = shreg;
  assign frame_done = done;

  // The bit count never goes past the frame length (R8).
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(FRAME_BITS));

  // Select high clears the count and the full flag on the next cycle (R7, R9).
  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> (cnt == '0 && !full));

  // Once full, further serial edges leave the frame untouched (R8).
  a_r8_full_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !sel_s) |=> $stable(shreg));

  // A frame completes only while select is held low (R7).
  a_r7_done_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (full && !sel_q));

endmodule

// File: rtl/dac_rx_decode.sv
`timescale 1ns/1ps
module dac_rx_decode
  import dac_rx_pkg::*;
#(
  parameter int FRAME_BITS = 32,
  parameter int HEAD_W     = 4,
  parameter int CMD_W      = 4,
  parameter int ADDR_W     = 4,
  parameter int WIDE_W     = 16,
  parameter int NARROW_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic                  frame_done,
  output logic                  upd_valid,
  output logic [CMD_W-1:0]      upd_cmd,
  output logic [ADDR_W-1:0]     upd_addr,
  output logic [WIDE_W-1:0]     upd_data
);

  localparam int CMD_LSB  = FRAME_BITS - HEAD_W - CMD_W;
  localparam int ADDR_LSB = CMD_LSB - ADDR_W;
  localparam int DATA_MSB = ADDR_LSB - 1;
  localparam int PAD_W    = WIDE_W - NARROW_W;

  function automatic chan_grp_e classify(input logic [ADDR_W-1:0] a);
    if (int'(a) >= BCAST_ADDR_LO)                               return GRP_ALL;
    else if (int'(a) >= NARROW_ADDR_LO && int'(a) <= NARROW_ADDR_HI) return GRP_NARROW;
    else                                                        return GRP_WIDE;
  endfunction

  logic [CMD_W-1:0]  cmd_f;
  logic [ADDR_W-1:0] addr_f;
  logic [WIDE_W-1:0] data_f;
  chan_grp_e         grp;

  assign cmd_f  = frame_word[CMD_LSB +: CMD_W];
  assign addr_f = frame_word[ADDR_LSB +: ADDR_W];
  assign grp    = classify(addr_f);

  always_comb begin
    case (grp)
      GRP_NARROW: data_f = {{PAD_W{1'b0}}, frame_word[DATA_MSB -: NARROW_W]};
      default:    data_f = frame_word[DATA_MSB -: WIDE_W];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_cmd   <= '0;
      upd_addr  <= '0;
      upd_data  <= '0;
    end else begin
      upd_valid <= frame_done;
      if (frame_done) begin
        upd_cmd  <= cmd_f;
        upd_addr <= addr_f;
        upd_data <= data_f;
      end
    end
  end

  // The strobe is a single cycle wide (R2).
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

  // A strobe only ever follows a completed frame (R7).
  a_r7_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(frame_done));

  // With no completed frame, the fields hold their values (R7).
  a_r7_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> ($stable(upd_data) && $stable(upd_cmd) && $stable(upd_addr)));

  // Narrow channels carry zeros above the 12-bit field (R5).
  a_r5_narrow_pad: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && int'(upd_addr) >= NARROW_ADDR_LO && int'(upd_addr) <= NARROW_ADDR_HI)
      |-> (upd_data[WIDE_W-1:NARROW_W] == '0));

endmodule

// File: rtl/dac_cmd_rx.sv
`timescale 1ns/1ps
module dac_cmd_rx #(
  parameter int FRAME_BITS  = 32,
  parameter int HEAD_W      = 4,
  parameter int CMD_W       = 4,
  parameter int ADDR_W      = 4,
  parameter int WIDE_W      = 16,
  parameter int NARROW_W    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              upd_valid,
  output logic [CMD_W-1:0]  upd_cmd,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [WIDE_W-1:0] upd_data
);

  // Order inside the synchronised vector: {select, clock, data}.
  localparam int PIN_N = 3;

  logic [PIN_N-1:0]      pins_s;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  frame_done;

  dac_rx_sync #(
    .WIDTH     (PIN_N),
    .STAGES    (SYNC_STAGES),
    .RESET_VAL (3'b110)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({ser_sel_n, ser_clk, ser_dat}),
    .q     (pins_s)
  );

  dac_rx_shifter #(
    .FRAME_BITS (FRAME_BITS)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_s     (pins_s[1]),
    .sel_s      (pins_s[2]),
    .din_s      (pins_s[0]),
    .frame_word (frame_word),
    .frame_done (frame_done)
  );

  dac_rx_decode #(
    .FRAME_BITS (FRAME_BITS),
    .HEAD_W     (HEAD_W),
    .CMD_W      (CMD_W),
    .ADDR_W     (ADDR_W),
    .WIDE_W     (WIDE_W),
    .NARROW_W   (NARROW_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_word (frame_word),
    .frame_done (frame_done),
    .upd_valid  (upd_valid),
    .upd_cmd    (upd_cmd),
    .upd_addr   (upd_addr),
    .upd_data   (upd_data)
  );

endmodule

// File: tb/dac_cmd_rx_test.sv
`timescale 1ns/1ps
module dac_cmd_rx_test;

  localparam int CLK_NS  = 10;
  localparam int HALF_NS = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_sel_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_dat = 1'b0;
  logic        upd_valid;
  logic [3:0]  upd_cmd;
  logic [3:0]  upd_addr;
  logic [15:0] upd_data;

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int doubles = 0;
  int strobes_before_rise = 0;
  logic prev_v = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  dac_cmd_rx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_sel_n (ser_sel_n),
    .ser_clk   (ser_clk),
    .ser_dat   (ser_dat),
    .upd_valid (upd_valid),
    .upd_cmd   (upd_cmd),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (upd_valid) strobes++;
      if (upd_valid && prev_v) doubles++;
      prev_v <= upd_valid;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_data(input logic [31:0] w);
    int a = int'(w[23:20]);
    if (a >= 2 && a <= 5) return {4'h0, w[19:8]};
    return w[19:4];
  endfunction

  task automatic send(input logic [31:0] w, input int nbits);
    ser_sel_n = 1'b0;
    #(2*HALF_NS);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 32) ? w[31-i] : 1'b1;
      #HALF_NS;
      ser_clk = 1'b0;
      #HALF_NS;
      ser_clk = 1'b1;
    end
    #(12*CLK_NS);
    strobes_before_rise = strobes;
    ser_sel_n = 1'b1;
    #(12*CLK_NS);
  endtask

  task automatic t_reset();
    chk("R1 valid", {31'd0, upd_valid}, 32'd0);
    chk("R1 cmd",   {28'd0, upd_cmd},   32'd0);
    chk("R1 addr",  {28'd0, upd_addr},  32'd0);
    chk("R1 data",  {16'd0, upd_data},  32'd0);
  endtask

  task automatic t_valid(input logic [31:0] w, input string req);
    int pre = strobes;
    send(w, 32);
    chk({req, " R2 one strobe"}, strobes, pre + 1);
    chk({req, " R10 strobe before select rise"}, strobes_before_rise, pre + 1);
    chk({req, " R3 cmd"},  {28'd0, upd_cmd},  {28'd0, w[27:24]});
    chk({req, " R3 addr"}, {28'd0, upd_addr}, {28'd0, w[23:20]});
    chk({req, " data"},    {16'd0, upd_data}, {16'd0, exp_data(w)});
  endtask

  task automatic t_abort(input logic [31:0] w, input int n);
    int pre = strobes;
    logic [3:0]  c0 = upd_cmd;
    logic [3:0]  a0 = upd_addr;
    logic [15:0] d0 = upd_data;
    send(w, n);
    chk("R7 no strobe", strobes, pre);
    chk("R7 cmd held",  {28'd0, upd_cmd},  {28'd0, c0});
    chk("R7 addr held", {28'd0, upd_addr}, {28'd0, a0});
    chk("R7 data held", {16'd0, upd_data}, {16'd0, d0});
  endtask

  task automatic t_over(input logic [31:0] w, input int extra);
    int pre = strobes;
    send(w, 32 + extra);
    chk("R8 one strobe", strobes, pre + 1);
    chk("R8 cmd",  {28'd0, upd_cmd},  {28'd0, w[27:24]});
    chk("R8 addr", {28'd0, upd_addr}, {28'd0, w[23:20]});
    chk("R8 data", {16'd0, upd_data}, {16'd0, exp_data(w)});
  endtask

  initial begin
    #(100_000 * CLK_NS);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5*CLK_NS + 2);
    t_reset();
    rst_n = 1'b1;
    #(10*CLK_NS);
    t_reset();

    t_valid(32'hF3_0_ABCD_F, "R4 addr0 junk head/tail");   // R3 head ignored, R4 tail ignored
    t_valid(32'h0_5_7_1234_0, "R4 addr7");
    t_valid(32'hA_9_1_8001_5, "R4 addr1");
    t_valid(32'h5_C_3_9A5_FF, "R5 addr3 junk tail");
    t_valid(32'h0_1_2_FFF_AA, "R5 addr2 boundary");
    t_valid(32'h0_E_5_123_77, "R5 addr5 boundary");
    t_valid(32'h0_2_8_C3A5_9, "R6 addr8 broadcast");
    t_valid(32'h7_6_F_5A5A_3, "R6 addr15 broadcast");

    t_abort(32'h0_3_0_FFFF_0, 1);
    t_abort(32'h0_3_4_FFF_00, 16);
    t_abort(32'h0_3_6_FFFF_0, 31);
    t_valid(32'h0_4_6_0F0F_0, "R9 after abort");
    t_abort(32'hF_F_F_FFFF_F, 20);
    t_valid(32'h0_8_4_001_00, "R9 narrow after abort");

    t_over(32'h0_D_6_2468_0, 5);
    t_over(32'h0_B_2_ACE_00, 3);

    chk("R2 no double-wide strobe", doubles, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule